// File: doc/BRIEF.md
# Reloadable Up/Down Timer-Counter

This block keeps a 16-bit count that moves up or down by one step per count event. Events come from one of three sources. In timer mode a free-running prescaler divides the block clock by a power of two. In pulse mode each rising edge on an external input is one event. In quadrature mode two phase inputs from a rotary or linear encoder are decoded, and their phase order gives the direction. Software drives it through a small register port. The port exposes a control word, a reload value, the live count, a pair of write-one-to-clear event flags and their interrupt masks.

When the count wraps past its top or bottom, the matching event flag is set. The count normally wraps to the opposite end. In quadrature mode with reload switched on, the wrap instead loads the reload value, so an encoder can keep a position modulo a chosen span. The interrupt output is high while any unmasked flag is set.

Top module: `updn_timer`

## Requirements
- R1: After reset the count, control, reload, flag and mask registers read 0, and `irq` is low.
- R2: Register addresses: 0 control (8 bits), 1 reload (16), 2 count (16), 3 flags (2), 4 mask (2). Addresses 5 to 7 read 0. Control bits: [0] run, [1] down, [3:2] source (0 prescaled clock, 1 pulse with direction from bit 1, 2 quadrature, 3 pulse with direction from `ph_b`, where 1 means down), [4] reload enable, [7:5] prescale exponent n.
- R3: In timer mode the count steps once every 2^n clocks. The first step comes 2^n clocks after the run bit is written.
- R4: With source 0 or 1, the direction bit picks up (0) or down (1).
- R5: While the run bit is 0 the count holds its value.
- R6: A write to the count appears on the next clock and overrides any step in that cycle.
- R7: In pulse modes, each rising edge of `ph_a`, after a two-flop synchroniser, moves the count by one. With source 3, `ph_b` high means down.
- R8: In quadrature mode, the sequence {ph_a,ph_b} 00→01→11→10→00 counts up and the reverse order counts down. A change of both phases at once is ignored.
- R9: Stepping up from 0xFFFF sets flag bit 0. Stepping down from 0x0000 sets flag bit 1. Without reload the count wraps to 0x0000 or 0xFFFF.
- R10: The wrap loads the reload value only when the source is quadrature and reload is enabled. Otherwise reload enable has no effect.
- R11: Writing 1 to a flag bit clears it, and writing 0 leaves it. `irq` is the OR of the flags ANDed with the mask bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr` (combinational) |
| ph_a | input | 1 | External count input / quadrature phase A |
| ph_b | input | 1 | Direction input / quadrature phase B |
| irq | output | 1 | Interrupt request |

## Verification
Timer mode is run over a table of prescale exponents, directions and start values for a fixed window of 32 clocks. This separates a wrong divider from a wrong direction or a wrong wrap. Pulse mode is tried with both direction sources, which shows whether `ph_b` steers the count only when source 3 is selected. The quadrature inputs get a forward lap, a partial reverse and an illegal double change. These patterns tell phase-order decoding apart from plain edge counting. Wraps are forced with reload on, in both quadrature and timer mode, so the mode-dependent reload rule is visible.

// File: rtl/updn_timer_pkg.sv
package updn_timer_pkg;
   typedef enum logic [1:0] {
      SRC_PRESC = 2'd0,
      SRC_PULSE = 2'd1,
      SRC_QUAD  = 2'd2,
      SRC_PDIR  = 2'd3
   } src_e;

   typedef struct packed {
      logic [2:0] presc;
      logic       rld_en;
      src_e       src;
      logic       down;
      logic       run;
   } ctrl_t;

   localparam logic [2:0] A_CTRL = 3'd0;
   localparam logic [2:0] A_RLD  = 3'd1;
   localparam logic [2:0] A_CNT  = 3'd2;
   localparam logic [2:0] A_FLAG = 3'd3;
   localparam logic [2:0] A_MASK = 3'd4;
endpackage

// File: rtl/updn_timer_presc.sv
module updn_timer_presc #(
   parameter int PRE_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PRE_W-1:0] sel,
   output logic             tick
);
   localparam int PCW = (1 << PRE_W) - 1;

   generate
      if (PRE_W < 1 || PRE_W > 4) begin : g_bad
         $error("updn_timer_presc: PRE_W out of range");
      end
   endgenerate

   logic [PCW-1:0] cnt_q;
   logic [PCW-1:0] msk;

   always_comb begin
      msk  = (PCW'(1) << sel) - PCW'(1);
      tick = run && ((cnt_q & msk) == msk);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (!run) cnt_q <= '0;
      else          cnt_q <= cnt_q + PCW'(1);
   end
endmodule

// File: rtl/updn_timer_extin.sv
module updn_timer_extin #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic ph_a,
   input  logic ph_b,
   output logic rise_a,
   output logic lvl_b,
   output logic q_step,
   output logic q_dn
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad
         $error("updn_timer_extin: need at least two sync stages");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sa_q, sb_q;
   logic                   pa_q, pb_q;
   logic [1:0]             cur, prv;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sa_q <= '0;
         sb_q <= '0;
         pa_q <= 1'b0;
         pb_q <= 1'b0;
      end else begin
         sa_q <= {sa_q[SYNC_STAGES-2:0], ph_a};
         sb_q <= {sb_q[SYNC_STAGES-2:0], ph_b};
         pa_q <= sa_q[SYNC_STAGES-1];
         pb_q <= sb_q[SYNC_STAGES-1];
      end
   end

   always_comb begin
      cur    = {sa_q[SYNC_STAGES-1], sb_q[SYNC_STAGES-1]};
      prv    = {pa_q, pb_q};
      rise_a = cur[1] && !prv[1];
      lvl_b  = cur[0];
      q_step = (cur[1] ^ prv[1]) ^ (cur[0] ^ prv[0]);
      q_dn   = !((prv == 2'b00 && cur == 2'b01) || (prv == 2'b01 && cur == 2'b11) ||
                 (prv == 2'b11 && cur == 2'b10) || (prv == 2'b10 && cur == 2'b00));
   end
endmodule

// File: rtl/updn_timer_cnt.sv
module updn_timer_cnt #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step,
   input  logic             down,
   input  logic             use_rld,
   input  logic [CNT_W-1:0] rld_val,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] count,
   output logic             ovf,
   output logic             unf
);
   generate
      if (CNT_W < 2) begin : g_bad
         $error("updn_timer_cnt: CNT_W too small");
      end
   endgenerate

   logic [CNT_W-1:0] cnt_q, nxt;
   logic             top, bot;

   always_comb begin
      top = (cnt_q == '1);
      bot = (cnt_q == '0);
      ovf = step && !wr && !down && top;
      unf = step && !wr && down && bot;
      if (ovf || unf) nxt = use_rld ? rld_val : (down ? '1 : '0);
      else if (down)  nxt = cnt_q - CNT_W'(1);
      else            nxt = cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt_q <= '0;
      else if (wr)   cnt_q <= wdata;
      else if (step) cnt_q <= nxt;
   end

   assign count = cnt_q;
endmodule

// File: rtl/updn_timer.sv
module updn_timer
   import updn_timer_pkg::*;
#(
   parameter int CNT_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [2:0]       reg_addr,
   input  logic [CNT_W-1:0] reg_wdata,
   output logic [CNT_W-1:0] reg_rdata,
   input  logic             ph_a,
   input  logic             ph_b,
   output logic             irq
);
   localparam int PRE_W = 3;

   generate
      if (CNT_W < 8) begin : g_bad
         $error("updn_timer: CNT_W must hold the control word");
      end
   endgenerate

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] rld_q;
   logic [1:0]       flag_q, mask_q;
   logic [CNT_W-1:0] count;
   logic             ptick, rise_a, lvl_b, q_step, q_dn;
   logic             step, dn, ovf, unf, cnt_wr;

   updn_timer_presc #(.PRE_W(PRE_W)) u_presc (
      .clk(clk), .rst_n(rst_n),
      .run(ctrl_q.run && ctrl_q.src == SRC_PRESC),
      .sel(ctrl_q.presc), .tick(ptick)
   );

   updn_timer_extin #(.SYNC_STAGES(SYNC_STAGES)) u_ext (
      .clk(clk), .rst_n(rst_n), .ph_a(ph_a), .ph_b(ph_b),
      .rise_a(rise_a), .lvl_b(lvl_b), .q_step(q_step), .q_dn(q_dn)
   );

   always_comb begin
      unique case (ctrl_q.src)
         SRC_PRESC: begin step = ptick;  dn = ctrl_q.down; end
         SRC_PULSE: begin step = rise_a; dn = ctrl_q.down; end
         SRC_QUAD:  begin step = q_step; dn = q_dn;        end
         default:   begin step = rise_a; dn = lvl_b;       end
      endcase
      step   = step && ctrl_q.run;
      cnt_wr = reg_wr && reg_addr == A_CNT;
   end

   updn_timer_cnt #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .step(step), .down(dn),
      .use_rld(ctrl_q.rld_en && ctrl_q.src == SRC_QUAD),
      .rld_val(rld_q), .wr(cnt_wr), .wdata(reg_wdata),
      .count(count), .ovf(ovf), .unf(unf)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         rld_q  <= '0;
         mask_q <= '0;
         flag_q <= '0;
      end else begin
         if (reg_wr && reg_addr == A_CTRL) ctrl_q <= ctrl_t'(reg_wdata[7:0]);
         if (reg_wr && reg_addr == A_RLD)  rld_q  <= reg_wdata;
         if (reg_wr && reg_addr == A_MASK) mask_q <= reg_wdata[1:0];
         flag_q <= (flag_q & ~((reg_wr && reg_addr == A_FLAG) ? reg_wdata[1:0] : 2'b00))
                   | {unf, ovf};
      end
   end

   always_comb begin
      unique case (reg_addr)
         A_CTRL:  reg_rdata = CNT_W'(ctrl_q);
         A_RLD:   reg_rdata = rld_q;
         A_CNT:   reg_rdata = count;
         A_FLAG:  reg_rdata = CNT_W'(flag_q);
         A_MASK:  reg_rdata = CNT_W'(mask_q);
         default: reg_rdata = '0;
      endcase
   end

   assign irq = |(flag_q & mask_q);
endmodule

// File: rtl/updn_timer_chk.sv
module updn_timer_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] wdata,
   input logic [CNT_W-1:0] count,
   input logic             run,
   input logic             quad_rld,
   input logic             ovf,
   input logic             unf,
   input logic [1:0]       flags,
   input logic [1:0]       mask,
   input logic             irq
);
   // R6
   cnt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> count == $past(wdata));
   // R5
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!run && !cnt_wr) |=> $stable(count));
   // R9
   ovf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ovf |=> flags[0]);
   // R9
   unf_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      unf |=> flags[1]);
   // R10
   no_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf && !quad_rld) |=> count == '0);
   // R11
   irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == 2'b00) |-> !irq);
endmodule

bind updn_timer updn_timer_chk #(.CNT_W(CNT_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .wdata(reg_wdata),
   .count(count), .run(ctrl_q.run),
   .quad_rld(ctrl_q.rld_en && ctrl_q.src == updn_timer_pkg::SRC_QUAD),
   .ovf(ovf), .unf(unf), .flags(flag_q), .mask(mask_q), .irq(irq)
);

// File: tb/updn_timer_tb.sv
`timescale 1ns/1ps
module updn_timer_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [15:0] reg_wdata = 16'd0;
   logic [15:0] reg_rdata;
   logic        ph_a = 1'b0, ph_b = 1'b0;
   logic        irq;
   int          n_run = 0, n_fail = 0;
   logic        done = 1'b0;

   always #4 clk = ~clk;

   updn_timer u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .ph_a(ph_a), .ph_b(ph_b), .irq(irq)
   );

   typedef struct packed {
      logic [7:0]  ctrl;
      logic [15:0] start;
      logic [15:0] expc;
      logic [1:0]  flg;
   } vec_t;

   // 32 counted clocks per row
   localparam vec_t VEC [10] = '{
      '{8'h01, 16'h0100, 16'h0120, 2'b00},  // R3 n=0 up
      '{8'h21, 16'h0100, 16'h0110, 2'b00},  // R3 n=1
      '{8'h61, 16'h0000, 16'h0004, 2'b00},  // R3 n=3
      '{8'hA1, 16'h0007, 16'h0008, 2'b00},  // R3 n=5
      '{8'hE1, 16'h0000, 16'h0000, 2'b00},  // R3 n=7
      '{8'h03, 16'h0050, 16'h0030, 2'b00},  // R4 down
      '{8'h01, 16'hFFF0, 16'h0010, 2'b01},  // R9 overflow
      '{8'h11, 16'hFFF0, 16'h0010, 2'b01},  // R10 reload ignored in timer mode
      '{8'h03, 16'h0010, 16'hFFF0, 2'b10},  // R9 underflow
      '{8'h00, 16'h1234, 16'h1234, 2'b00}   // R5 disabled
   };

   task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
      n_run++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic pulse_a();
      ph_a = 1'b1; repeat (4) @(negedge clk);
      ph_a = 1'b0; repeat (4) @(negedge clk);
   endtask

   task automatic quad(input logic [1:0] v);
      {ph_a, ph_b} = v;
      repeat (4) @(negedge clk);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_run++; n_fail++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [15:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      for (int a = 0; a < 5; a++) begin
         rd(3'(a), v);
         chk("R1 reset reg", v, 16'h0000);
      end
      chk("R1 irq", {15'd0, irq}, 16'h0000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R2 register map
      wr(3'd1, 16'hBEEF); rd(3'd1, v); chk("R2 reload rw", v, 16'hBEEF);
      wr(3'd4, 16'hFFFE); rd(3'd4, v); chk("R2 mask rw", v, 16'h0002);
      wr(3'd4, 16'h0000);
      rd(3'd7, v); chk("R2 unused addr", v, 16'h0000);

      // table walk: timer mode
      foreach (VEC[i]) begin
         wr(3'd3, 16'h0003);
         wr(3'd2, VEC[i].start);
         wr(3'd0, {8'h00, VEC[i].ctrl});
         repeat (30) @(negedge clk);
         wr(3'd0, 16'h0000);
         rd(3'd2, v); chk($sformatf("R3/R4/R5/R9/R10 row %0d count", i), v, VEC[i].expc);
         rd(3'd3, v); chk($sformatf("R9 row %0d flags", i), v, {14'd0, VEC[i].flg});
      end

      // R6 write priority while counting
      wr(3'd0, 16'h0001);
      repeat (3) @(negedge clk);
      wr(3'd2, 16'h4000);
      rd(3'd2, v); chk("R6 write wins", v, 16'h4000);
      @(negedge clk);
      rd(3'd2, v); chk("R6 counts after write", v, 16'h4001);
      wr(3'd0, 16'h0000);

      // R7 pulse mode, direction from control
      wr(3'd2, 16'h0100);
      wr(3'd0, 16'h0005);
      pulse_a(); pulse_a(); pulse_a();
      rd(3'd2, v); chk("R7 pulse up", v, 16'h0103);
      wr(3'd0, 16'h0007);
      pulse_a(); pulse_a();
      rd(3'd2, v); chk("R7 pulse down", v, 16'h0101);
      // R7 direction from ph_b
      wr(3'd0, 16'h0000);
      ph_b = 1'b1; repeat (4) @(negedge clk);
      wr(3'd0, 16'h000D);
      pulse_a(); pulse_a();
      rd(3'd2, v); chk("R7 ph_b down", v, 16'h00FF);
      wr(3'd0, 16'h0000);
      ph_b = 1'b0; repeat (4) @(negedge clk);
      wr(3'd0, 16'h000D);
      pulse_a();
      rd(3'd2, v); chk("R7 ph_b up", v, 16'h0100);
      wr(3'd0, 16'h0000);

      // R8 quadrature
      wr(3'd0, 16'h0009);
      quad(2'b01); quad(2'b11); quad(2'b10); quad(2'b00);
      rd(3'd2, v); chk("R8 quad forward", v, 16'h0104);
      quad(2'b10); quad(2'b11);
      rd(3'd2, v); chk("R8 quad reverse", v, 16'h0102);
      quad(2'b00);
      rd(3'd2, v); chk("R8 double change ignored", v, 16'h0102);
      wr(3'd0, 16'h0000);

      // R10 reload in quadrature mode
      wr(3'd3, 16'h0003);
      wr(3'd1, 16'h0500);
      wr(3'd2, 16'hFFFF);
      wr(3'd0, 16'h0019);
      quad(2'b01);
      rd(3'd2, v); chk("R10 reload on overflow", v, 16'h0500);
      rd(3'd3, v); chk("R9 overflow flag quad", v, 16'h0001);
      wr(3'd2, 16'h0000);
      quad(2'b00);
      rd(3'd2, v); chk("R10 reload on underflow", v, 16'h0500);
      rd(3'd3, v); chk("R9 both flags", v, 16'h0003);
      wr(3'd0, 16'h0000);

      // R11 mask and write-one-to-clear
      chk("R11 masked irq low", {15'd0, irq}, 16'h0000);
      wr(3'd4, 16'h0002);
      chk("R11 unmasked irq", {15'd0, irq}, 16'h0001);
      wr(3'd3, 16'h0001);
      rd(3'd3, v); chk("R11 clear bit0 only", v, 16'h0002);
      chk("R11 irq still high", {15'd0, irq}, 16'h0001);
      wr(3'd3, 16'h0002);
      rd(3'd3, v); chk("R11 all clear", v, 16'h0000);
      chk("R11 irq low", {15'd0, irq}, 16'h0000);

      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule